// File: doc/BRIEF.md
# Limit-Compare Interval Timer

This block is a processor interval timer. A 32-bit up-counter advances by one on every clock where it is allowed to run. When it equals a software-set limit value, the next advance puts it back at zero. That event is an expiry. It sets a sticky pending flag, which software reads and clears through a small register port. The port has an address, a write strobe, write data and registered read data.

A set of control bits decides what an expiry drives. If interrupt enable is set, the pending flag appears on a level interrupt line. If watchdog mode is set, each expiry gives a one-cycle reset request, and the interrupt line stays quiet. A third control bit ties counting to the processor's halt input, so the count freezes while the core is halted. Software has no way to stop the counter outright. It can only move the count, move the limit, or mask the interrupt line.

Top module: `ivt_timer`

## Requirements
- R1: While reset is high and on the first clock after it, count, control and limit read as zero, and `irq_o`, `wdt_reset_o` and `reg_rdata` are low.
- R2: Register select on `reg_addr`: 0 is count, 1 is control, 2 is limit, and 3 reads zero.
  - `reg_rdata` shows the selected register one clock after the address is presented.
  - Control reads back bit 0 interrupt enable, bit 1 halt-gating, bit 2 watchdog and bit 3 pending. All higher bits read zero.
- R3: On each clock where the counter runs and no count write happens, the count increases by one.
  - When the count equals the limit, it goes to zero instead.
  - A limit of L gives an expiry every L+1 running clocks.
  - A limit of all ones wraps from the maximum value to zero.
- R4: An expiry sets the pending flag. With a limit of zero, an expiry happens on every running clock.
- R5: The pending flag stays set until a control write carries 0 in bit 3. Writing 1 in bit 3 leaves the flag unchanged. An expiry in the same clock as a clearing write leaves the flag set.
- R6: `irq_o` is a registered level. It is high exactly while the pending flag is set, interrupt enable is set and watchdog mode is clear.
- R7: With watchdog mode set, each expiry raises `wdt_reset_o` for one clock, and `irq_o` stays low.
- R8: With control bit 1 set and `halt_in` high, the count holds. With bit 1 clear, `halt_in` has no effect, and no control value stops counting.
- R9: A count write loads the written value on that clock. It takes priority over an advance in the same clock, and that clock produces no expiry.
- R10: A limit write takes effect for the current period and leaves the count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 2 | Register select |
| reg_we | input | 1 | Write strobe for the selected register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| halt_in | input | 1 | Processor halted indication |
| irq_o | output | 1 | Level interrupt request |
| wdt_reset_o | output | 1 | One-clock reset request in watchdog mode |

## Verification
A corrupted count or limit shows up first as an expiry in the wrong clock. `irq_o` or `wdt_reset_o` rises early or late within one period, and a frozen count read gives a wrong value on the next read. A corrupted pending flag or enable bit appears on `irq_o` in the clock after it changes, and persists because the flag is sticky. The bench freezes the counter through the halt gating so that reads and expiry clocks can be predicted exactly. Two cases get exact checks: a count write landing on a match clock, and a limit of all ones wrapping to zero.

// File: rtl/ivt_pkg.sv
package ivt_pkg;
  localparam int unsigned SEL_W = 2;

  typedef enum logic [SEL_W-1:0] {
    SEL_COUNT = 2'd0,
    SEL_CTRL  = 2'd1,
    SEL_LIMIT = 2'd2,
    SEL_NONE  = 2'd3
  } reg_sel_e;

  localparam int unsigned CTRL_W = 4;

  // bit order matters: it is the software-visible control layout
  typedef struct packed {
    logic pend;  // bit 3
    logic wd;    // bit 2
    logic nh;    // bit 1
    logic ie;    // bit 0
  } ctrl_t;
endpackage

// File: rtl/ivt_counter.sv
module ivt_counter #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         run_en,
  input  logic         cnt_we,
  input  logic         lim_we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] cnt_q,
  output logic [W-1:0] lim_q,
  output logic         expire
);
  logic hit;

  assign hit    = (cnt_q == lim_q);
  // a software load on the match clock suppresses the expiry
  assign expire = run_en && hit && !cnt_we;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (cnt_we) begin
      cnt_q <= wdata;
    end else if (run_en) begin
      cnt_q <= hit ? '0 : cnt_q + W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lim_q <= '0;
    end else if (lim_we) begin
      lim_q <= wdata;
    end
  end
endmodule

// File: rtl/ivt_ctrl.sv
module ivt_ctrl
  import ivt_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              ctl_we,
  input  logic [CTRL_W-1:0] wbits,
  input  logic              expire,
  input  logic              halt_in,
  output ctrl_t             ctrl_q,
  output logic              run_en,
  output logic              irq_o,
  output logic              wdt_reset_o
);
  ctrl_t nxt;

  assign run_en = !(ctrl_q.nh && halt_in);

  always_comb begin
    nxt = ctrl_q;
    if (ctl_we) begin
      nxt.ie   = wbits[0];
      nxt.nh   = wbits[1];
      nxt.wd   = wbits[2];
      nxt.pend = ctrl_q.pend & wbits[3];
    end
    if (expire) nxt.pend = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q      <= '0;
      irq_o       <= 1'b0;
      wdt_reset_o <= 1'b0;
    end else begin
      ctrl_q      <= nxt;
      irq_o       <= nxt.pend & nxt.ie & ~nxt.wd;
      wdt_reset_o <= expire & ctrl_q.wd;
    end
  end
endmodule

// File: rtl/ivt_readmux.sv
module ivt_readmux
  import ivt_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SEL_W-1:0] sel,
  input  logic [W-1:0]     cnt_val,
  input  logic [W-1:0]     lim_val,
  input  ctrl_t            ctrl_val,
  output logic [W-1:0]     rdata
);
  logic [W-1:0] mux;

  always_comb begin
    unique case (reg_sel_e'(sel))
      SEL_COUNT: mux = cnt_val;
      SEL_CTRL:  mux = {{(W-CTRL_W){1'b0}}, ctrl_val};
      SEL_LIMIT: mux = lim_val;
      default:   mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= mux;
  end
endmodule

// File: rtl/ivt_timer.sv
module ivt_timer
  import ivt_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SEL_W-1:0] reg_addr,
  input  logic             reg_we,
  input  logic [W-1:0]     reg_wdata,
  output logic [W-1:0]     reg_rdata,
  input  logic             halt_in,
  output logic             irq_o,
  output logic             wdt_reset_o
);
  logic         cnt_we, ctl_we, lim_we;
  logic         run_en, expire;
  logic [W-1:0] cnt_val, lim_val;
  ctrl_t        ctrl_q;

  assign cnt_we = reg_we && (reg_sel_e'(reg_addr) == SEL_COUNT);
  assign ctl_we = reg_we && (reg_sel_e'(reg_addr) == SEL_CTRL);
  assign lim_we = reg_we && (reg_sel_e'(reg_addr) == SEL_LIMIT);

  ivt_counter #(.W(W)) counter_i (
    .clk    (clk),
    .rst    (rst),
    .run_en (run_en),
    .cnt_we (cnt_we),
    .lim_we (lim_we),
    .wdata  (reg_wdata),
    .cnt_q  (cnt_val),
    .lim_q  (lim_val),
    .expire (expire)
  );

  ivt_ctrl ctrl_i (
    .clk         (clk),
    .rst         (rst),
    .ctl_we      (ctl_we),
    .wbits       (reg_wdata[CTRL_W-1:0]),
    .expire      (expire),
    .halt_in     (halt_in),
    .ctrl_q      (ctrl_q),
    .run_en      (run_en),
    .irq_o       (irq_o),
    .wdt_reset_o (wdt_reset_o)
  );

  ivt_readmux #(.W(W)) readmux_i (
    .clk      (clk),
    .rst      (rst),
    .sel      (reg_addr),
    .cnt_val  (cnt_val),
    .lim_val  (lim_val),
    .ctrl_val (ctrl_q),
    .rdata    (reg_rdata)
  );
endmodule

// File: rtl/ivt_timer_chk.sv
module ivt_timer_chk #(
  parameter int unsigned W = 32
) (
  input logic         clk,
  input logic         rst,
  input logic [W-1:0] cnt_val,
  input logic [W-1:0] lim_val,
  input logic [W-1:0] reg_wdata,
  input logic         cnt_we,
  input logic         ctl_we,
  input logic         run_en,
  input logic         halt_in,
  input logic         nh,
  input logic         wd,
  input logic         pend,
  input logic         irq_o,
  input logic         wdt_reset_o
);
  p_step_r3: assert property (@(posedge clk) disable iff (rst)
    (!cnt_we && run_en && cnt_val != lim_val) |=> cnt_val == $past(cnt_val) + W'(1));

  p_wrap_r4: assert property (@(posedge clk) disable iff (rst)
    (!cnt_we && run_en && cnt_val == lim_val) |=> (cnt_val == '0 && pend));

  p_sticky_r5: assert property (@(posedge clk) disable iff (rst)
    (pend && !ctl_we) |=> pend);

  p_irq_level_r6: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> (pend && !wd));

  p_wdt_pend_r7: assert property (@(posedge clk) disable iff (rst)
    wdt_reset_o |-> pend);

  p_halt_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (!cnt_we && nh && halt_in) |=> $stable(cnt_val));

  p_load_wins_r9: assert property (@(posedge clk) disable iff (rst)
    cnt_we |=> cnt_val == $past(reg_wdata));
endmodule

bind ivt_timer ivt_timer_chk #(.W(W)) chk_i (
  .clk         (clk),
  .rst         (rst),
  .cnt_val     (cnt_val),
  .lim_val     (lim_val),
  .reg_wdata   (reg_wdata),
  .cnt_we      (cnt_we),
  .ctl_we      (ctl_we),
  .run_en      (run_en),
  .halt_in     (halt_in),
  .nh          (ctrl_q.nh),
  .wd          (ctrl_q.wd),
  .pend        (ctrl_q.pend),
  .irq_o       (irq_o),
  .wdt_reset_o (wdt_reset_o)
);

// File: tb/ivt_timer_tb_top.sv
module ivt_timer_tb_top;
  localparam int unsigned W = 32;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [1:0]   reg_addr = '0;
  logic         reg_we = 1'b0;
  logic [W-1:0] reg_wdata = '0;
  logic [W-1:0] reg_rdata;
  logic         halt_in = 1'b1;
  logic         irq_o, wdt_reset_o;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  logic         rd_req = 1'b0;
  logic         rd_req_q = 1'b0;
  logic [W-1:0] exp_q[$];
  string        tag_q[$];

  always #5 clk = ~clk;

  ivt_timer #(.W(W)) dut_i (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .halt_in(halt_in),
    .irq_o(irq_o), .wdt_reset_o(wdt_reset_o)
  );

  always @(posedge clk) rd_req_q <= rd_req;

  // monitor: compares each read result against the queued expectation
  always @(negedge clk) begin
    if (rd_req_q && exp_q.size() > 0) begin
      logic [W-1:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      total++;
      if (reg_rdata !== e) begin
        bad++;
        $display("FAIL %s read: actual=%h expected=%h", t, reg_rdata, e);
      end
    end
  end

  task automatic chk(input string t, input logic [W-1:0] act, input logic [W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", t, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [W-1:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(posedge clk); #1;
    reg_we = 1'b0;
  endtask

  // driver: issues a read and pushes the expected value
  task automatic rd(input logic [1:0] a, input logic [W-1:0] e, input string t);
    @(negedge clk);
    reg_addr = a; rd_req = 1'b1;
    exp_q.push_back(e); tag_q.push_back(t);
    @(posedge clk); #1;
    rd_req = 1'b0;
  endtask

  // let the counter run for exactly k clock edges, then halt it again
  task automatic win(input int k);
    @(negedge clk);
    halt_in = 1'b0;
    repeat (k) @(negedge clk);
    halt_in = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 irq in reset", {31'b0, irq_o}, 0);
    chk("R1 wdt in reset", {31'b0, wdt_reset_o}, 0);
    chk("R1 rdata in reset", reg_rdata, 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 irq after reset", {31'b0, irq_o}, 0);
    // limit 0, halt gating off: expiry every clock
    rd(2'd1, 32'h8, "R4 limit0 pending");
    rd(2'd0, 32'h0, "R1 count zero");
    rd(2'd2, 32'h0, "R1 limit zero");
    rd(2'd3, 32'h0, "R2 unused address");
    // first write still expires (gating not yet on), second clears
    wr(2'd1, 32'h2);
    wr(2'd1, 32'h2);
    rd(2'd1, 32'h2, "R5 pending cleared");
    wr(2'd0, 32'd10);
    wr(2'd2, 32'd20);
    rd(2'd0, 32'd10, "R8 count frozen by halt");
    rd(2'd2, 32'd20, "R2 limit readback");
    win(5);
    rd(2'd0, 32'd15, "R3 five steps");
    wr(2'd0, 32'd3);
    rd(2'd0, 32'd3, "R9 reposition");
    // gating off while halted: exactly one running edge before re-enabled
    wr(2'd1, 32'h0);
    wr(2'd1, 32'h2);
    rd(2'd0, 32'd4, "R8 halt ignored without gating");
    // expiry with interrupt enable
    wr(2'd0, 32'd18);
    wr(2'd1, 32'h3);
    win(2);
    chk("R6 irq before expiry", {31'b0, irq_o}, 0);
    rd(2'd0, 32'd20, "R3 at limit");
    win(1);
    chk("R6 irq on expiry", {31'b0, irq_o}, 1);
    rd(2'd0, 32'd0, "R3 wrap to zero");
    rd(2'd1, 32'hB, "R4 pending set");
    wr(2'd1, 32'hB);
    rd(2'd1, 32'hB, "R5 write 1 keeps pending");
    wr(2'd1, 32'hA);
    @(negedge clk);
    chk("R6 irq masked by enable", {31'b0, irq_o}, 0);
    rd(2'd1, 32'hA, "R5 pending stays while masked");
    wr(2'd1, 32'h3);
    @(negedge clk);
    chk("R5 clear drops irq", {31'b0, irq_o}, 0);
    // period of limit+1
    wr(2'd2, 32'd4);
    wr(2'd0, 32'd0);
    win(4);
    chk("R3 no irq at 4 of 5", {31'b0, irq_o}, 0);
    win(1);
    chk("R3 irq at 5 of 5", {31'b0, irq_o}, 1);
    wr(2'd1, 32'h3);
    // limit rewrite keeps count
    wr(2'd0, 32'd10);
    wr(2'd2, 32'd12);
    rd(2'd0, 32'd10, "R10 count kept");
    win(2);
    chk("R10 no irq before new limit", {31'b0, irq_o}, 0);
    win(1);
    chk("R10 irq at new limit", {31'b0, irq_o}, 1);
    wr(2'd1, 32'h3);
    // count write on a match clock wins and suppresses expiry
    wr(2'd2, 32'd7);
    wr(2'd0, 32'd7);
    wr(2'd1, 32'h1);
    wr(2'd0, 32'd2);
    wr(2'd1, 32'h3);
    rd(2'd0, 32'd3, "R9 load beats wrap");
    rd(2'd1, 32'h3, "R9 no expiry on load");
    chk("R9 irq low", {31'b0, irq_o}, 0);
    // full-width wrap
    wr(2'd2, 32'hFFFF_FFFF);
    wr(2'd0, 32'hFFFF_FFFE);
    wr(2'd1, 32'h2);
    win(1);
    rd(2'd0, 32'hFFFF_FFFF, "R3 max value");
    win(1);
    rd(2'd0, 32'h0, "R3 max wraps to zero");
    rd(2'd1, 32'hA, "R4 pending on max wrap");
    // watchdog mode
    wr(2'd1, 32'h7);
    wr(2'd2, 32'd1);
    wr(2'd0, 32'd0);
    win(1);
    chk("R7 no request early", {31'b0, wdt_reset_o}, 0);
    win(1);
    chk("R7 request on expiry", {31'b0, wdt_reset_o}, 1);
    chk("R7 irq held low", {31'b0, irq_o}, 0);
    @(negedge clk);
    chk("R7 request one clock", {31'b0, wdt_reset_o}, 0);
    rd(2'd1, 32'hF, "R2 control readback");
    repeat (2) @(negedge clk);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule